// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a small first-in-first-out store of instruction bytes between a 16-bit memory fetch port and a decoder that consumes one byte per read strobe. It watches its own free space and asks the memory side for another aligned word whenever at least two byte slots are open. The low and high bytes of each returned word go into the queue in address order.

A flush input abandons everything queued, loads a new target byte address and restarts fetching there. When the target is odd, the first returned word supplies only its upper byte. When the queue is empty, the first byte of an arriving word is offered to the consumer in the same cycle, so a restart costs no extra cycle. Only one fetch is outstanding at a time. The fetch port is a request/grant pair followed by a data-valid strobe carrying the word. A word that was requested before a flush is dropped when it comes back.

Top module: `ifetch_queue`

## Requirements
- R1: The queue never holds more than DEPTH bytes (6 by default); with no reads, filling from empty stops after DEPTH/2 word fetches.
- R2: `fetch_req_o` is high exactly when no fetch is outstanding, no flush is applied and at most DEPTH-2 bytes are held; `fetch_addr_o` is always even (bit 0 is zero).
- R3: Bytes leave in fetch order, one per cycle in which `byte_rd_i` and `byte_valid_o` are both high; within a word, the byte at the even address (bits 7:0 of `fetch_rdata_i`) comes before the byte at the odd address (bits 15:8).
- R4: With the queue empty, in the cycle `fetch_rvalid_i` returns a kept word, `byte_valid_o` is high and `byte_o` shows its first byte; a read in that cycle takes it, and the remaining byte is shown in the next cycle.
- R5: In the cycle `flush_i` is high, `byte_valid_o` is low; after the flush edge the queue is empty and `fetch_addr_o` equals `flush_addr_i` with bit 0 cleared.
- R6: After a flush to an odd address, only bits 15:8 of the first returned word are queued, and the next fetch goes to the following even address.
- R7: Each completed fetch that is kept advances `fetch_addr_o` by 2.
- R8: A word requested before a flush and returned after it is discarded, and no new request is issued until it has returned.
- R9: `byte_rd_i` has no effect while the queue is empty and no word is arriving.
- R10: A request not granted stays high with `fetch_addr_o` unchanged until `fetch_gnt_i` or a flush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty the queue and restart fetching |
| flush_addr_i | input | AW | Byte address to restart at |
| fetch_req_o | output | 1 | Word fetch request |
| fetch_addr_o | output | AW | Even byte address of the requested word |
| fetch_gnt_i | input | 1 | Request accepted this cycle |
| fetch_rvalid_i | input | 1 | Returned word valid |
| fetch_rdata_i | input | 16 | Returned word, even-address byte in bits 7:0 |
| byte_valid_o | output | 1 | A byte is offered to the consumer |
| byte_o | output | 8 | Offered byte |
| byte_rd_i | input | 1 | Consumer takes the offered byte |

## Verification
The bench builds the block with its defaults, DEPTH of 6 and AW of 20, so the full state and the two-free-slot threshold are reached after three word fetches and a couple of reads. A behavioural memory with adjustable return latency makes each byte value a function of its own address, so order, odd restarts and stale words show up as wrong values. Long latencies open a window to flush with a fetch outstanding and to watch the bypass cycle on an empty queue.

// File: rtl/ifq_pkg.sv
`timescale 1ns/1ps
package ifq_pkg;
  typedef logic [7:0] byte_t;

  // bytes handed to the store in one cycle, b0 first
  typedef struct packed {
    logic [1:0] n;
    byte_t      b0;
    byte_t      b1;
  } ifq_wr_t;
endpackage

// File: rtl/ifq_store.sv
`timescale 1ns/1ps
module ifq_store
  import ifq_pkg::*;
#(
  parameter int unsigned DEPTH = 6,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  ifq_wr_t       wr_i,
  input  logic          pop_i,
  output logic [CW-1:0] count_o,
  output byte_t         head_o
);

  byte_t          mem_q [DEPTH];
  logic [PW-1:0]  wptr_q, rptr_q;
  logic [CW-1:0]  count_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_i.n != 2'd0) mem_q[wptr_q] <= wr_i.b0;
    if (wr_i.n == 2'd2) mem_q[nxt(wptr_q)] <= wr_i.b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else if (flush_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (wr_i.n == 2'd2)      wptr_q <= nxt(nxt(wptr_q));
      else if (wr_i.n == 2'd1) wptr_q <= nxt(wptr_q);
      if (pop_i) rptr_q <= nxt(rptr_q);
      count_q <= count_q + CW'(wr_i.n) - CW'(pop_i);
    end
  end

  assign count_o = count_q;
  assign head_o  = mem_q[rptr_q];

  p_no_overflow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));

  p_flush_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> count_q == '0);

endmodule

// File: rtl/ifq_fetch.sv
`timescale 1ns/1ps
module ifq_fetch #(
  parameter int unsigned DEPTH = 6,
  parameter int unsigned AW = 20,
  parameter logic [AW-1:0] RST_ADDR = '0,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic [AW-1:0] flush_addr_i,
  input  logic [CW-1:0] count_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  input  logic          gnt_i,
  input  logic          rvalid_i,
  output logic          accept_o,
  output logic          skip_o
);

  logic [AW-2:0] ptr_q;   // word index
  logic          skip_q;  // odd restart: drop low byte of next word
  logic          pend_q;  // fetch outstanding
  logic          drop_q;  // outstanding fetch is stale

  assign req_o    = !pend_q && !flush_i && (count_i <= CW'(DEPTH - 2));
  assign addr_o   = {ptr_q, 1'b0};
  assign accept_o = rvalid_i && pend_q && !drop_q && !flush_i;
  assign skip_o   = skip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= RST_ADDR[AW-1:1];
      skip_q <= RST_ADDR[0];
      pend_q <= 1'b0;
      drop_q <= 1'b0;
    end else if (flush_i) begin
      ptr_q  <= flush_addr_i[AW-1:1];
      skip_q <= flush_addr_i[0];
      pend_q <= pend_q && !rvalid_i;
      drop_q <= pend_q && !rvalid_i;
    end else begin
      if (req_o && gnt_i) pend_q <= 1'b1;
      if (rvalid_i && pend_q) begin
        pend_q <= 1'b0;
        drop_q <= 1'b0;
        if (!drop_q) begin
          ptr_q  <= ptr_q + 1'b1;
          skip_q <= 1'b0;
        end
      end
    end
  end

  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i) |=> (flush_i || req_o) && $stable(addr_o));

  p_ptr_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> addr_o == $past(addr_o) + AW'(2));

  p_stale_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && flush_i && !rvalid_i) |=> !accept_o && !req_o);

  p_even_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_o[0]);

endmodule

// File: rtl/ifetch_queue.sv
`timescale 1ns/1ps
module ifetch_queue
  import ifq_pkg::*;
#(
  parameter int unsigned DEPTH = 6,
  parameter int unsigned AW = 20,
  parameter logic [AW-1:0] RST_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic [AW-1:0] flush_addr_i,
  output logic          fetch_req_o,
  output logic [AW-1:0] fetch_addr_o,
  input  logic          fetch_gnt_i,
  input  logic          fetch_rvalid_i,
  input  logic [15:0]   fetch_rdata_i,
  output logic          byte_valid_o,
  output logic [7:0]    byte_o,
  input  logic          byte_rd_i
);

  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt;
  logic          accept, skip, empty, pop, take_byp;
  byte_t         head, in_b0, in_hi;
  ifq_wr_t       wr;

  ifq_fetch #(.DEPTH(DEPTH), .AW(AW), .RST_ADDR(RST_ADDR)) u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .flush_addr_i (flush_addr_i),
    .count_i      (cnt),
    .req_o        (fetch_req_o),
    .addr_o       (fetch_addr_o),
    .gnt_i        (fetch_gnt_i),
    .rvalid_i     (fetch_rvalid_i),
    .accept_o     (accept),
    .skip_o       (skip)
  );

  assign in_hi    = fetch_rdata_i[15:8];
  assign in_b0    = skip ? in_hi : fetch_rdata_i[7:0];
  assign empty    = (cnt == '0);
  assign byte_valid_o = !flush_i && (!empty || accept);
  assign byte_o   = empty ? in_b0 : head;
  assign pop      = byte_rd_i && byte_valid_o;
  assign take_byp = pop && empty;

  always_comb begin
    wr = '0;
    if (accept) begin
      if (take_byp) begin
        wr.n  = skip ? 2'd0 : 2'd1;
        wr.b0 = in_hi;
      end else begin
        wr.n  = skip ? 2'd1 : 2'd2;
        wr.b0 = in_b0;
        wr.b1 = in_hi;
      end
    end
  end

  ifq_store #(.DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .wr_i    (wr),
    .pop_i   (pop && !empty),
    .count_o (cnt),
    .head_o  (head)
  );

  p_empty_rd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_rd_i && empty && !accept) |=> cnt == '0);

  p_bypass_offer_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty && fetch_rvalid_i && $past(fetch_req_o && fetch_gnt_i) && !flush_i && !$past(flush_i))
      |-> byte_valid_o);

endmodule

// File: tb/sim_ifetch_queue.sv
`timescale 1ns/1ps
module sim_ifetch_queue;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic [AW-1:0] flush_addr = '0;
  logic          req;
  logic [AW-1:0] addr;
  logic          gnt = 1'b0;
  logic          rvalid = 1'b0;
  logic [15:0]   rdata = '0;
  logic          bvalid;
  logic [7:0]    bdata;
  logic          rd = 1'b0;

  int n_chk = 0, n_fail = 0;

  // memory model
  bit            resp_en = 1'b0;
  int            lat = 1;
  bit            busy = 1'b0;
  int            wait_c = 0;
  logic [AW-1:0] baddr = '0;
  logic [AW-1:0] gaddr [16];
  int            gcnt = 0;

  always #10 clk = ~clk;

  ifetch_queue u0 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .flush_addr_i(flush_addr),
    .fetch_req_o(req), .fetch_addr_o(addr), .fetch_gnt_i(gnt),
    .fetch_rvalid_i(rvalid), .fetch_rdata_i(rdata),
    .byte_valid_o(bvalid), .byte_o(bdata), .byte_rd_i(rd)
  );

  function automatic logic [7:0] bv(input logic [AW-1:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction

  function automatic logic [15:0] wv(input logic [AW-1:0] a);
    return {bv({a[AW-1:1], 1'b1}), bv({a[AW-1:1], 1'b0})};
  endfunction

  initial forever begin
    @(negedge clk); #1;
    rvalid = 1'b0;
    if (busy) begin
      if (wait_c <= 1) begin
        rvalid = 1'b1;
        rdata  = wv(baddr);
        busy   = 1'b0;
      end else wait_c--;
    end
    gnt = 1'b0;
    if (resp_en && req && !busy && !rvalid) begin
      gnt = 1'b1;
      busy = 1'b1;
      baddr = addr;
      wait_c = lat;
      gaddr[gcnt % 16] = addr;
      gcnt++;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_flush(input logic [AW-1:0] a);
    @(negedge clk);
    flush = 1'b1;
    flush_addr = a;
    gcnt = 0;
    #5 check(!bvalid, "R5 valid low in flush cycle", 32'(bvalid), 0);
    @(negedge clk);
    flush = 1'b0;
    #5 check(addr == {a[AW-1:1], 1'b0}, "R5 restart address", 32'(addr), 32'({a[AW-1:1], 1'b0}));
  endtask

  task automatic read_seq(input logic [AW-1:0] start, input int n, input string tag);
    logic [AW-1:0] exp = start;
    int got = 0;
    for (int i = 0; i < 400 && got < n; i++) begin
      @(negedge clk); #5;
      if (bvalid) begin
        check(bdata == bv(exp), tag, 32'(bdata), 32'(bv(exp)));
        rd = 1'b1;
        exp++;
        got++;
      end else rd = 1'b0;
    end
    check(got == n, {tag, " count"}, 32'(got), 32'(n));
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic t_reset_hold;
    check(!bvalid, "reset valid low", 32'(bvalid), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #5;
      check(req && addr == '0, "R10 req held at reset address", 32'({req, addr}), 32'({1'b1, 20'h0}));
    end
  endtask

  task automatic t_fill_threshold;
    resp_en = 1'b1; lat = 1;
    do_flush(20'h00100);
    repeat (20) @(negedge clk);
    #5;
    check(gcnt == 3, "R1 fetches to fill", 32'(gcnt), 3);
    check(gaddr[0] == 20'h00100 && gaddr[1] == 20'h00102 && gaddr[2] == 20'h00104,
          "R7 fetch addresses step by 2", 32'(gaddr[2]), 32'h104);
    check(!req, "R2 no req when full", 32'(req), 0);
    check(bvalid && bdata == bv(20'h00100), "R3 head byte low first", 32'(bdata), 32'(bv(20'h00100)));
    rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    #5 check(!req, "R2 no req with one free slot", 32'(req), 0);
    check(bdata == bv(20'h00101), "R3 high byte second", 32'(bdata), 32'(bv(20'h00101)));
    rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    #5 check(req && addr == 20'h00106, "R2 req at two free slots", 32'({req, addr}), 32'({1'b1, 20'h00106}));
    read_seq(20'h00102, 14, "R3 order after refill");
  endtask

  task automatic t_flush_full;
    lat = 1;
    do_flush(20'h00180);
    repeat (12) @(negedge clk);
    do_flush(20'h00140);
    check(!bvalid, "R5 empty after flush", 32'(bvalid), 0);
    read_seq(20'h00140, 8, "R5 restart stream");
  endtask

  task automatic t_bypass;
    resp_en = 1'b0;
    do_flush(20'h00200);
    @(negedge clk);
    lat = 3; resp_en = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); #5;
      if (rvalid) break;
      check(!bvalid, "R4 nothing before word", 32'(bvalid), 0);
    end
    check(bvalid && bdata == bv(20'h00200), "R4 bypass same cycle", 32'({bvalid, bdata}), 32'({1'b1, bv(20'h00200)}));
    rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    #5 check(bvalid && bdata == bv(20'h00201), "R4 remaining byte next", 32'({bvalid, bdata}), 32'({1'b1, bv(20'h00201)}));
    read_seq(20'h00201, 7, "R4 stream after bypass");
  endtask

  task automatic t_odd;
    lat = 2; resp_en = 1'b1;
    do_flush(20'h00301);
    read_seq(20'h00301, 7, "R6 odd restart bytes");
    check(gaddr[0] == 20'h00300 && gaddr[1] == 20'h00302, "R6 next fetch even",
          32'(gaddr[1]), 32'h302);
  endtask

  task automatic t_stale;
    lat = 4; resp_en = 1'b1;
    do_flush(20'h00400);
    @(negedge clk);
    do_flush(20'h00500);
    check(!req, "R8 no req while stale outstanding", 32'(req), 0);
    read_seq(20'h00500, 8, "R8 stale word discarded");
  endtask

  task automatic t_empty_read;
    resp_en = 1'b0;
    do_flush(20'h00600);
    rd = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #5;
      check(!bvalid, "R9 read on empty ignored", 32'(bvalid), 0);
    end
    rd = 1'b0;
    lat = 1; resp_en = 1'b1;
    read_seq(20'h00600, 6, "R9 stream intact after empty reads");
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #5;
    t_reset_hold();
    t_fill_threshold();
    t_flush_full();
    t_bypass();
    t_odd();
    t_stale();
    t_empty_read();
    finish_run();
  end
endmodule